// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Controller

This controller walks the elements of a vector operation one at a time, in strict order from element 0. For each element it asks the surrounding datapath for a status word through a request/acknowledge handshake. It then decides whether that element passes. The first element that fails ends the walk. The controller then reports a shortened vector length, so that the surviving elements form one contiguous run of passing results. Each passing element gets a commit-enable during its handshake, and a failing element never gets one.

There are two modes. In memory mode the status is a per-element "would fault" flag. A fault on the very first element is not absorbed: it raises an ordinary exception and leaves the length as it was. A fault on any later element truncates the length silently. In condition mode the status is a small condition field. One bit of it, picked by a selector, is compared against an expected polarity. A failure on the first element truncates the length all the way to zero. Memory access and arithmetic stay with the caller.

Top module: `vl_trunc_ctrl`

## Requirements
- R1: After an accepted start with a nonzero length, `elem_req_o` rises with `elem_idx_o` = 0. The index advances by exactly one after each acknowledged passing element. The request and index are held while `elem_ack_i` is low.
- R2: In memory mode (`mode_i` = 0), `fault_i` = 1 on element 0 raises `exc_o` for one cycle together with `done_o`, and `vl_o` equals the starting length.
- R3: In memory mode, `fault_i` = 1 on element i ≥ 1 sets `vl_o` = i and raises no exception. `cond_i`, `sel_i` and `pol_i` have no effect in this mode.
- R4: In condition mode (`mode_i` = 1), an element passes when `cond_i[sel_i]` equals `pol_i`, where `pol_i` = 1 means the bit must be 1. The first failure at element i sets `vl_o` = i with no exception, and `fault_i` has no effect.
- R5: In condition mode, a failure on element 0 gives `vl_o` = 0. In memory mode a nonzero starting length never yields `vl_o` = 0.
- R6: `commit_o` is high during the acknowledged handshake of a passing element, and is low for the failing element and outside handshakes. The number of commits equals the final `vl_o` for a truncated walk.
- R7: If no element fails, `vl_o` equals the starting length. `done_o` rises in the cycle after the handshake of the last element.
- R8: `done_o` is high for exactly one cycle after the final handshake. `vl_o` then holds its value until the next accepted start.
- R9: `start_i` is ignored while a walk or its done cycle is in progress. The running walk's result is unaffected, and no second walk follows.
- R10: A start with length 0 issues no element request, raises `done_o` in the next cycle with `vl_o` = 0, and raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a walk (taken only when idle) |
| mode_i | input | 1 | 0 = memory-fault mode, 1 = condition mode |
| vl_i | input | VLW | Starting vector length (0..VL_MAX) |
| sel_i | input | SELW | Condition bit selector |
| pol_i | input | 1 | Required value of the selected bit |
| elem_req_o | output | 1 | Status wanted for element `elem_idx_o` |
| elem_idx_o | output | VLW | Index of the element being examined |
| elem_ack_i | input | 1 | Status for the current element is valid |
| fault_i | input | 1 | Element would fault (memory mode) |
| cond_i | input | CRW | Element condition field (condition mode) |
| commit_o | output | 1 | Commit the result of the current element |
| vl_o | output | VLW | Truncated vector length |
| exc_o | output | 1 | Ordinary exception, pulses with done |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
The bench goes after the zero-length rules from both sides. A fault on element 0 in memory mode must raise an exception and keep the length, where a design that merged the modes would report 0. A condition failure on element 0 must give exactly 0, where a design that reused the memory rule would raise an exception. It also covers failure on the last element, full-length walks at the maximum length, and a start of length 0. A design with an off-by-one there would report the untruncated length or hang waiting for an element. The condition fields it drives make every unselected bit disagree with the selected one, so the wrong selector or an inverted polarity flips the pass decision. A start pulse during a walk checks that a busy controller does not relaunch or corrupt its latched length.

// File: rtl/vlt_pkg.sv
// Package: shared types for the fail-first truncation controller.
// Assumes: nothing beyond standard SystemVerilog.
package vlt_pkg;

    // Which per-element status decides pass or fail.
    typedef enum logic {
        MODE_MEM  = 1'b0,
        MODE_COND = 1'b1
    } ff_mode_e;

    // Walk sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vlt_elem_judge.sv
// Module: vlt_elem_judge
// Decides, combinationally, whether the element currently offered passes.
// Memory mode: passes when no fault is reported.
// Condition mode: passes when the selected condition bit equals the polarity.
// Assumes: CRW >= 2; sel is below CRW.
module vlt_elem_judge
    import vlt_pkg::*;
#(
    parameter int CRW = 4,
    localparam int SELW = $clog2(CRW)
) (
    input  ff_mode_e        mode,
    input  logic            fault,
    input  logic [CRW-1:0]  cond,
    input  logic [SELW-1:0] sel,
    input  logic            pol,
    output logic            pass
);

    logic [CRW-1:0] hit;
    logic           picked;

    // One-hot pick of the selected condition bit.
    for (genvar k = 0; k < CRW; k++) begin : g_pick
        assign hit[k] = (sel == SELW'(k)) & cond[k];
    end
    assign picked = |hit;

    // Per-mode pass decision.
    always_comb begin
        if (mode == MODE_MEM) pass = ~fault;
        else                  pass = (picked == pol);
    end

endmodule

// File: rtl/vlt_seq.sv
// Module: vlt_seq
// Walk sequencer. It latches the launch configuration, steps the element
// index from 0 in order, and stops at the first failing element or after the
// last one. On the stopping edge it emits a capture strobe with the new length
// and the exception flag.
// Assumes: vl_in <= VL_MAX; the status inputs are valid whenever ack is high.
module vlt_seq
    import vlt_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int CRW    = 4,
    localparam int VLW   = $clog2(VL_MAX + 1),
    localparam int SELW  = $clog2(CRW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  ff_mode_e        mode_in,
    input  logic [VLW-1:0]  vl_in,
    input  logic [SELW-1:0] sel_in,
    input  logic            pol_in,
    input  logic            ack,
    input  logic            pass,
    output logic            req,
    output logic [VLW-1:0]  idx,
    output logic            done,
    output ff_mode_e        mode_q,
    output logic [SELW-1:0] sel_q,
    output logic            pol_q,
    output logic [VLW-1:0]  vl_q,
    output logic            cap,
    output logic [VLW-1:0]  cap_len,
    output logic            cap_exc
);

    seq_state_e state;
    logic       launch;
    logic       last;
    logic       stop;

    assign launch = (state == ST_IDLE) && start;
    assign last   = (idx == vl_q - VLW'(1));
    assign stop   = (state == ST_WALK) && ack && (!pass || last);
    assign req    = (state == ST_WALK);
    assign done   = (state == ST_DONE);

    // State, index and latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            vl_q   <= '0;
            mode_q <= MODE_MEM;
            sel_q  <= '0;
            pol_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_in;
                        mode_q <= mode_in;
                        sel_q  <= sel_in;
                        pol_q  <= pol_in;
                        idx    <= '0;
                        state  <= (vl_in == '0) ? ST_DONE : ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (stop)            state <= ST_DONE;
                    else if (ack && pass) idx  <= idx + VLW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture strobe and the result it carries.
    always_comb begin
        cap     = 1'b0;
        cap_len = vl_q;
        cap_exc = 1'b0;
        if (launch && (vl_in == '0)) begin
            cap     = 1'b1;
            cap_len = '0;
        end else if (stop) begin
            cap = 1'b1;
            if (!pass) begin
                if (mode_q == MODE_MEM && idx == '0) begin
                    cap_len = vl_q;
                    cap_exc = 1'b1;
                end else begin
                    cap_len = idx;
                end
            end
        end
    end

    // R1: a nonzero launch begins at element 0
    p_first_elem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        launch && (vl_in != '0) |=> req && (idx == '0));

    // R1: an accepted passing element that is not the last advances the index by one
    p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack && pass && !last |=> req && (idx == $past(idx) + VLW'(1)));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start while busy leaves the latched length alone
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && start |=> vl_q == $past(vl_q));

    // R10: a zero-length launch goes straight to done without a request
    p_zero_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch && (vl_in == '0) |=> done && !req);

endmodule

// File: rtl/vlt_result.sv
// Module: vlt_result
// Holds the reported length and the exception flag. It loads them on the
// sequencer's capture strobe and keeps them until the next capture.
// Assumes: cap is a single-cycle strobe followed by one done cycle.
module vlt_result
    import vlt_pkg::*;
#(
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap,
    input  logic [VLW-1:0] cap_len,
    input  logic           cap_exc,
    input  logic           done,
    input  ff_mode_e       mode_q,
    input  logic [VLW-1:0] src_len,
    output logic [VLW-1:0] vl_out,
    output logic           exc_out
);

    logic exc_q;

    // Load the result registers on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_out <= '0;
            exc_q  <= 1'b0;
        end else if (cap) begin
            vl_out <= cap_len;
            exc_q  <= cap_exc;
        end
    end

    assign exc_out = done & exc_q;

    // R2: an exception keeps the starting length
    p_exc_keeps_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_out |-> vl_out == src_len);

    // R5: memory mode never reports zero for a nonzero start
    p_mem_never_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && (mode_q == MODE_MEM) && (src_len != '0) |-> vl_out != '0);

    // R4: condition mode never raises an exception
    p_cond_no_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && (mode_q == MODE_COND) |-> !exc_out);

endmodule

// File: rtl/vl_trunc_ctrl.sv
// Module: vl_trunc_ctrl (top)
// Fail-first vector length truncation. It walks elements in order, judges
// each from the caller's status, commits passing elements and reports the
// truncated length.
// Assumes: the caller answers each request with ack and valid status; vl_i <= VL_MAX.
module vl_trunc_ctrl
    import vlt_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int CRW    = 4,
    localparam int VLW   = $clog2(VL_MAX + 1),
    localparam int SELW  = $clog2(CRW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic [VLW-1:0]  vl_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            pol_i,
    output logic            elem_req_o,
    output logic [VLW-1:0]  elem_idx_o,
    input  logic            elem_ack_i,
    input  logic            fault_i,
    input  logic [CRW-1:0]  cond_i,
    output logic            commit_o,
    output logic [VLW-1:0]  vl_o,
    output logic            exc_o,
    output logic            done_o
);

    ff_mode_e        mode_q;
    logic [SELW-1:0] sel_q;
    logic            pol_q;
    logic [VLW-1:0]  vl_q;
    logic            pass;
    logic            cap;
    logic [VLW-1:0]  cap_len;
    logic            cap_exc;

    vlt_elem_judge #(.CRW(CRW)) i_judge (
        .mode  (mode_q),
        .fault (fault_i),
        .cond  (cond_i),
        .sel   (sel_q),
        .pol   (pol_q),
        .pass  (pass)
    );

    vlt_seq #(.VL_MAX(VL_MAX), .CRW(CRW)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .mode_in (ff_mode_e'(mode_i)),
        .vl_in   (vl_i),
        .sel_in  (sel_i),
        .pol_in  (pol_i),
        .ack     (elem_ack_i),
        .pass    (pass),
        .req     (elem_req_o),
        .idx     (elem_idx_o),
        .done    (done_o),
        .mode_q  (mode_q),
        .sel_q   (sel_q),
        .pol_q   (pol_q),
        .vl_q    (vl_q),
        .cap     (cap),
        .cap_len (cap_len),
        .cap_exc (cap_exc)
    );

    vlt_result #(.VLW(VLW)) i_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .cap_len (cap_len),
        .cap_exc (cap_exc),
        .done    (done_o),
        .mode_q  (mode_q),
        .src_len (vl_q),
        .vl_out  (vl_o),
        .exc_out (exc_o)
    );

    // Commit-enable: a passing element during its handshake.
    assign commit_o = elem_req_o & elem_ack_i & pass;

    // R6: any committed element lies below the length finally reported
    p_commit_below_vl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !done_o || (vl_o > $past(elem_idx_o)));

endmodule

// File: tb/test_vl_trunc_ctrl.sv
module test_vl_trunc_ctrl;

    localparam int VLW = 7;
    localparam int CRW = 4;
    localparam int NV  = 11;
    localparam logic [7:0] NONE = 8'hFF;

    // Vector: [31] mode, [30] pol, [29:28] sel, [27:20] vl, [19:12] fail index, [11:8] stall
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 8'd5,  NONE,  4'd0, 8'd0},
        {1'b0, 1'b1, 2'd1, 8'd6,  8'd0,  4'd1, 8'd0},
        {1'b0, 1'b0, 2'd2, 8'd8,  8'd3,  4'd0, 8'd0},
        {1'b0, 1'b1, 2'd3, 8'd4,  8'd3,  4'd2, 8'd0},
        {1'b1, 1'b1, 2'd2, 8'd7,  8'd4,  4'd2, 8'd0},
        {1'b1, 1'b0, 2'd1, 8'd5,  8'd0,  4'd0, 8'd0},
        {1'b1, 1'b1, 2'd0, 8'd3,  NONE,  4'd1, 8'd0},
        {1'b1, 1'b0, 2'd3, 8'd1,  8'd0,  4'd0, 8'd0},
        {1'b0, 1'b0, 2'd0, 8'd1,  8'd0,  4'd0, 8'd0},
        {1'b1, 1'b1, 2'd3, 8'd64, NONE,  4'd1, 8'd0},
        {1'b0, 1'b1, 2'd1, 8'd64, 8'd63, 4'd0, 8'd0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           mode_i = 1'b0;
    logic [VLW-1:0] vl_i = '0;
    logic [1:0]     sel_i = '0;
    logic           pol_i = 1'b0;
    logic           elem_req_o;
    logic [VLW-1:0] elem_idx_o;
    logic           elem_ack_i = 1'b0;
    logic           fault_i = 1'b0;
    logic [CRW-1:0] cond_i = '0;
    logic           commit_o;
    logic [VLW-1:0] vl_o;
    logic           exc_o;
    logic           done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vl_trunc_ctrl #(.VL_MAX(64), .CRW(CRW)) i_vl_trunc_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .vl_i(vl_i), .sel_i(sel_i), .pol_i(pol_i), .elem_req_o(elem_req_o),
        .elem_idx_o(elem_idx_o), .elem_ack_i(elem_ack_i), .fault_i(fault_i),
        .cond_i(cond_i), .commit_o(commit_o), .vl_o(vl_o), .exc_o(exc_o),
        .done_o(done_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Condition field whose selected bit passes or fails; all other bits disagree with it.
    function automatic logic [CRW-1:0] make_cond(input logic [1:0] sel, input logic bitval);
        logic [CRW-1:0] c;
        c = {CRW{~bitval}};
        c[sel] = bitval;
        return c;
    endfunction

    // One walk: launch, answer each request, then check the result and the done pulse.
    task automatic run_walk(input logic mode, input logic pol, input logic [1:0] sel,
                            input int vl, input int fail, input int stall, input logic poke);
        int  exp_len;
        logic exp_exc;
        int  expect_idx = 0;
        int  n_commit = 0;
        int  waits = 0;
        logic acked_prev = 1'b0;
        logic got_done = 1'b0;
        logic passing;
        int  held;
        exp_exc = (mode == 1'b0) && (fail == 0) && (vl > 0);
        if (fail >= vl)    exp_len = vl;
        else if (exp_exc)  exp_len = vl;
        else               exp_len = fail;
        @(negedge clk);
        start_i = 1'b1; mode_i = mode; pol_i = pol; sel_i = sel; vl_i = VLW'(vl);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 3000 && !got_done; c++) begin
            elem_ack_i = 1'b0;
            start_i = 1'b0;
            if (done_o) begin
                got_done = 1'b1;
                // R7 / R10: done comes right after the last handshake (or launch for length 0)
                check(acked_prev || (vl == 0 && c == 0), "R7 done timing", c, 0);
            end else if (elem_req_o) begin
                acked_prev = 1'b0;
                if (poke && expect_idx == 1) begin
                    start_i = 1'b1; vl_i = VLW'(2); mode_i = ~mode;  // R9 start while busy
                end
                if (waits < stall) begin
                    waits++;
                    #1;
                    check(commit_o == 1'b0, "R6 no commit while stalled", commit_o, 0);
                end else begin
                    waits = 0;
                    check(elem_idx_o == VLW'(expect_idx), "R1 element order", elem_idx_o, expect_idx);
                    passing = (expect_idx != fail);
                    elem_ack_i = 1'b1;
                    if (mode == 1'b0) begin
                        fault_i = ~passing;
                        cond_i  = make_cond(sel, ~pol);   // R3 would fail if consulted
                    end else begin
                        fault_i = 1'b1;                   // R4 would fail if consulted
                        cond_i  = make_cond(sel, passing ? pol : ~pol);
                    end
                    #1;
                    check(commit_o == passing, "R6 commit enable", commit_o, passing);
                    if (passing) n_commit++;
                    expect_idx++;
                    acked_prev = 1'b1;
                end
            end else begin
                acked_prev = 1'b0;
                check(1'b0, "R1 request missing", 0, 1);
                got_done = 1'b1;
            end
            if (!got_done) @(negedge clk);
        end
        elem_ack_i = 1'b0;
        start_i = 1'b0;
        check(got_done, "R8 done seen", got_done, 1);
        // R2 R3 R4 R5 R7: reported length and exception
        check(vl_o == VLW'(exp_len), mode ? "R4 cond length" : "R3 mem length", vl_o, exp_len);
        check(exc_o == exp_exc, "R2 exception", exc_o, exp_exc);
        if (mode == 1'b1 && fail == 0)
            check(vl_o == '0, "R5 cond zero length", vl_o, 0);
        if (mode == 1'b0 && vl > 0)
            check(vl_o != '0, "R5 mem nonzero", vl_o, 1);
        check(n_commit == (exp_exc ? 0 : exp_len), "R6 commit count", n_commit, exp_len);
        held = vl_o;
        @(negedge clk);
        check(done_o == 1'b0 && exc_o == 1'b0, "R8 single done", done_o, 0);
        check(elem_req_o == 1'b0, "R9 no relaunch", elem_req_o, 0);
        @(negedge clk);
        check(vl_o == VLW'(held), "R8 length held", vl_o, held);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 0 && elem_req_o == 0 && exc_o == 0 && vl_o == 0 && commit_o == 0,
              "R8 reset state", done_o, 0);

        for (int v = 0; v < NV; v++) begin
            run_walk(VEC[v][31], VEC[v][30], VEC[v][29:28], int'(VEC[v][27:20]),
                     (VEC[v][19:12] == NONE) ? 1000 : int'(VEC[v][19:12]),
                     int'(VEC[v][11:8]), 1'b0);
        end

        // R10: zero starting length, both modes
        run_walk(1'b0, 1'b0, 2'd0, 0, 1000, 0, 1'b0);
        run_walk(1'b1, 1'b1, 2'd2, 0, 1000, 0, 1'b0);

        // R9: start pulses during a busy walk are ignored
        run_walk(1'b1, 1'b0, 2'd1, 4, 1000, 0, 1'b1);
        run_walk(1'b0, 1'b1, 2'd0, 5, 3, 1, 1'b1);

        // R4: polarity flips the pass decision on the same selector
        run_walk(1'b1, 1'b0, 2'd0, 6, 2, 0, 1'b0);
        run_walk(1'b1, 1'b1, 2'd0, 6, 5, 0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule